// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Almost Flags

This block is a first-in first-out buffer, nine bits wide, whose write side and read side run on clocks that are unrelated to each other. The depth is a parameter (512 words by default, a power of two). Words go in on the write clock when the write enables allow it and the buffer has room. Words come out on the read clock into a registered output when both read enables are low and the buffer holds data. A separate output enable puts the data outputs into high impedance.

Four active-low flags show how full the buffer is. Empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. The two thresholds for the almost flags can be changed. The level on the dual-role pin while reset is held picks one of two port modes. In the first mode the pin is a second write enable. In the second mode it is a load/readback strobe. When it is low, write edges store the data inputs into the threshold registers, and read edges put those registers onto the data outputs in place of buffered data.

Pointers cross between the clocks as Gray codes through two-flop synchronizers. Each flag therefore compares a local pointer with a delayed copy of the remote one. A flag may assert early or release late, but it never reports data or room that is not there.

Top module: `dc_fifo9_progflags`

## Requirements
- R1: On a rising `wclk` edge the word on `din` is stored if and only if `wen1_n` is low, `ld_wen2` is high and `full_n` is high. Stored words come out in the order they were written.
- R2: On a rising `rclk` edge the oldest word is moved into the output register if and only if `ren1_n` and `ren2_n` are both low, `empty_n` is high and no readback is selected. With only one read enable low, nothing is read.
- R3: A write attempt while `full_n` is low changes neither the stored contents nor the write pointer. A read attempt while `empty_n` is low leaves the output register and the read pointer unchanged.
- R4: The level of `ld_wen2` on the clock edges while `rst_n` is low picks the mode. High selects dual-enable mode, where `ld_wen2` low blocks writes. Low selects programmable mode, where `wen1_n` alone enables writes while `ld_wen2` is high.
- R5: In programmable mode, a `wclk` edge with `wen1_n` low and `ld_wen2` low loads a threshold from the low address bits of `din` and stores no word. Loads alternate: the empty threshold first, then the full threshold. While `ld_wen2` is high, the next load goes to the empty threshold again.
- R6: In programmable mode, an `rclk` edge with both read enables low and `ld_wen2` low puts a threshold on `q`, zero-extended to 9 bits. The order is the same as for loads: empty threshold first, then full threshold, restarting whenever `ld_wen2` is high. The buffered data and the read pointer stay untouched.
- R7: After reset `empty_n`=0, `pae_n`=0, `full_n`=1, `paf_n`=1, the output register is 0, and both thresholds are 7.
- R8: Once the pointers have settled, `pae_n` is low exactly when the stored count is at or below the empty threshold. It changes only on `rclk` edges and is low whenever `empty_n` is low.
- R9: Once the pointers have settled, `paf_n` is low exactly when the free space (depth minus count) is at or below the full threshold. It changes only on `wclk` edges and is low whenever `full_n` is low.
- R10: `empty_n` and `full_n` are exact once the pointers have settled. At any time, `empty_n` high implies at least one stored word and `full_n` high implies at least one free location. Each pointer's Gray code changes by at most one bit per edge of its own clock.
- R11: With `oe_n` high, `q` is high impedance. With `oe_n` low, `q` drives the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| wen1_n | input | 1 | Primary write enable, active low |
| ld_wen2 | input | 1 | Second write enable (dual-enable mode) or load/readback strobe, active low (programmable mode) |
| din | input | 9 | Write data or threshold value |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | 9 | Read data or threshold readback, high impedance when disabled |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| pae_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| paf_n | output | 1 | Almost-full flag, active low, write-clock domain |

## Verification
The bench fills the buffer to full and keeps writing distinct words. A design that honoured writes while full would overwrite the oldest entry, and the drain that follows would show a wrong word. It reads past empty and checks that the output register holds. A design that popped anyway would move `q` or leave the pointers skewed for the next phase. Both threshold boundaries are approached one word at a time, with the default value and with loaded values. This catches an off-by-one between "at or below" and "below". Threshold loads and readbacks are interleaved with `ld_wen2` going high, which exposes a select bit that fails to restart or that disturbs the buffered words.

// File: rtl/fifo9_pkg.sv
// Shared constants and the port-mode type for the dual-clock 9-bit FIFO.
// Assumes nothing beyond IEEE 1800-2017 package semantics.
package fifo9_pkg;
    localparam int DATA_W     = 9;
    localparam int DEF_OFFSET = 7;

    typedef enum logic {
        PORT_DUAL_EN = 1'b0,
        PORT_PROG    = 1'b1
    } port_mode_e;
endpackage

// File: rtl/fifo9_ptr_sync.sv
// Brings a Gray-coded pointer into the local clock domain through two
// flops and converts it back to binary.
// Assumes the source changes at most one bit per source-clock edge.
module fifo9_ptr_sync #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] stab_q;

    // Two-stage capture of the remote Gray pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= gray_in;
            stab_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all higher Gray bits.
    generate
        for (genvar i = 0; i < PW; i++) begin : g_g2b
            assign bin_out[i] = ^stab_q[PW-1:i];
        end
    endgenerate
endmodule

// File: rtl/fifo9_ram.sv
// Storage array: written on the write clock, read combinationally at the
// read address. The read side registers the result.
// Assumes DEPTH is a power of two.
module fifo9_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo9_wr_side.sv
// Write-clock logic: mode capture, write pointer, threshold registers with
// their load select, and the full / almost-full flags.
// Assumes rbin_s is the read pointer already synchronized to wclk; the
// count it yields is an over-estimate, so the flags are conservative.
module fifo9_wr_side
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wen1_n,
    input  logic              ld_wen2,
    input  logic [DATA_W-1:0] din,
    input  logic [PW-1:0]     rbin_s,
    output logic [PW-1:0]     wgray,
    output logic [AW-1:0]     waddr,
    output logic              we,
    output logic [AW-1:0]     eoff,
    output logic [AW-1:0]     foff,
    output logic              full_n,
    output logic              paf_n
);
    port_mode_e    mode_q;
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] wcnt_nxt;
    logic          full_n_q;
    logic          paf_n_q;
    logic          sel_q;
    logic [AW-1:0] eoff_q;
    logic [AW-1:0] foff_q;
    logic          push;
    logic          load;

    assign push     = !wen1_n && ld_wen2 && full_n_q;
    assign load     = (mode_q == PORT_PROG) && !wen1_n && !ld_wen2;
    assign wbin_nxt = wbin_q + PW'(push);
    assign wcnt_nxt = wbin_nxt - rbin_s;

    // Latch the port mode from the dual-role pin while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode_q <= ld_wen2 ? PORT_DUAL_EN : PORT_PROG;
        end
    end

    // Advance the write pointer and its Gray image.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Full and almost-full from the count after this edge.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            full_n_q <= 1'b1;
            paf_n_q  <= 1'b1;
        end else begin
            full_n_q <= (wcnt_nxt != PW'(DEPTH));
            paf_n_q  <= ((PW'(DEPTH) - wcnt_nxt) > PW'(foff_q));
        end
    end

    // Threshold loads alternate empty/full; strobe high restarts at empty.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            eoff_q <= AW'(DEF_OFFSET);
            foff_q <= AW'(DEF_OFFSET);
            sel_q  <= 1'b0;
        end else if (ld_wen2) begin
            sel_q  <= 1'b0;
        end else if (load) begin
            if (sel_q) begin
                foff_q <= AW'(din);
            end else begin
                eoff_q <= AW'(din);
            end
            sel_q <= ~sel_q;
        end
    end

    assign wgray  = wgray_q;
    assign waddr  = wbin_q[AW-1:0];
    assign we     = push;
    assign eoff   = eoff_q;
    assign foff   = foff_q;
    assign full_n = full_n_q;
    assign paf_n  = paf_n_q;

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (wbin_q - rbin_s) <= PW'(DEPTH)) else $error("write pointer ran past depth"); // R3
    AST_FULL_IMPLIES_PAF: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n_q |-> !paf_n_q) else $error("full without almost-full"); // R9
    AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1) else $error("write Gray jumped"); // R10
endmodule

// File: rtl/fifo9_rd_side.sv
// Read-clock logic: mode capture, read pointer, output register with
// threshold readback, and the empty / almost-empty flags.
// Assumes wbin_s is the write pointer synchronized to rclk (an
// under-estimate of the count) and that thresholds are loaded while the
// read side is not using them, so they are sampled without a synchronizer.
module fifo9_rd_side
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              ld_wen2,
    input  logic [PW-1:0]     wbin_s,
    input  logic [DATA_W-1:0] rdata,
    input  logic [AW-1:0]     eoff,
    input  logic [AW-1:0]     foff,
    output logic [PW-1:0]     rgray,
    output logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] q_reg,
    output logic              empty_n,
    output logic              pae_n
);
    port_mode_e        mode_q;
    logic [PW-1:0]     rbin_q;
    logic [PW-1:0]     rgray_q;
    logic [PW-1:0]     rbin_nxt;
    logic [PW-1:0]     rcnt_nxt;
    logic [DATA_W-1:0] q_q;
    logic              empty_n_q;
    logic              pae_n_q;
    logic              sel_q;
    logic              rd_req;
    logic              peek;
    logic              pop;

    assign rd_req   = !ren1_n && !ren2_n;
    assign peek     = (mode_q == PORT_PROG) && !ld_wen2 && rd_req;
    assign pop      = rd_req && !peek && empty_n_q;
    assign rbin_nxt = rbin_q + PW'(pop);
    assign rcnt_nxt = wbin_s - rbin_nxt;

    // Latch the port mode from the dual-role pin while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode_q <= ld_wen2 ? PORT_DUAL_EN : PORT_PROG;
        end
    end

    // Advance the read pointer and its Gray image.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else begin
            rbin_q  <= rbin_nxt;
            rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Empty and almost-empty from the count after this edge.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            empty_n_q <= 1'b0;
            pae_n_q   <= 1'b0;
        end else begin
            empty_n_q <= (rcnt_nxt != '0);
            pae_n_q   <= (rcnt_nxt > PW'(eoff));
        end
    end

    // Output register: threshold readback has priority over a data pop.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (peek) begin
            q_q <= sel_q ? DATA_W'(foff) : DATA_W'(eoff);
        end else if (pop) begin
            q_q <= rdata;
        end
    end

    // Readback select toggles per readback; strobe high restarts at empty.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (ld_wen2) begin
            sel_q <= 1'b0;
        end else if (peek) begin
            sel_q <= ~sel_q;
        end
    end

    assign rgray   = rgray_q;
    assign raddr   = rbin_q[AW-1:0];
    assign q_reg   = q_q;
    assign empty_n = empty_n_q;
    assign pae_n   = pae_n_q;

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (wbin_s - rbin_q) <= PW'(DEPTH)) else $error("read pointer passed write pointer"); // R3
    AST_EMPTY_IMPLIES_PAE: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n_q |-> !pae_n_q) else $error("empty without almost-empty"); // R8
    AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray_q ^ $past(rgray_q)) <= 1) else $error("read Gray jumped"); // R10
endmodule

// File: rtl/dc_fifo9_progflags.sv
// Top of the dual-clock 9-bit FIFO with programmable almost flags.
// Connects the write side, read side, storage and the two pointer
// synchronizers, and drives the output bus under the output enable.
// Assumes DEPTH is a power of two and rst_n is held for several edges of
// both clocks.
module dc_fifo9_progflags
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen1_n,
    input  logic              ld_wen2,
    input  logic [DATA_W-1:0] din,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              full_n,
    output logic              pae_n,
    output logic              paf_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wbin_s;
    logic [PW-1:0]     rbin_s;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic              we;
    logic [AW-1:0]     eoff;
    logic [AW-1:0]     foff;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] q_reg;

    fifo9_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .wen1_n  (wen1_n),
        .ld_wen2 (ld_wen2),
        .din     (din),
        .rbin_s  (rbin_s),
        .wgray   (wgray),
        .waddr   (waddr),
        .we      (we),
        .eoff    (eoff),
        .foff    (foff),
        .full_n  (full_n),
        .paf_n   (paf_n)
    );

    fifo9_rd_side #(.DEPTH(DEPTH)) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .ren1_n  (ren1_n),
        .ren2_n  (ren2_n),
        .ld_wen2 (ld_wen2),
        .wbin_s  (wbin_s),
        .rdata   (rdata),
        .eoff    (eoff),
        .foff    (foff),
        .rgray   (rgray),
        .raddr   (raddr),
        .q_reg   (q_reg),
        .empty_n (empty_n),
        .pae_n   (pae_n)
    );

    fifo9_ram #(.DEPTH(DEPTH), .DW(DATA_W)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    fifo9_ptr_sync #(.PW(PW)) u_sync_w2r (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_s)
    );

    fifo9_ptr_sync #(.PW(PW)) u_sync_r2w (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_s)
    );

    assign q = oe_n ? {DATA_W{1'bz}} : q_reg;
endmodule

// File: tb/sim_dc_fifo9_progflags.sv
`timescale 1ns/1ps
// Bench: behavioural queue model checked on every write and read clock.
module sim_dc_fifo9_progflags;
    localparam int DEPTH = 512;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wen1_n = 1'b1;
    logic       ld_wen2 = 1'b1;
    logic [8:0] din = '0;
    logic       ren1_n = 1'b1;
    logic       ren2_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [8:0] q;
    logic       empty_n, full_n, pae_n, paf_n;

    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic [8:0] mq[$];
    int         eoff_m = 7;
    int         foff_m = 7;
    bit         rd_pend = 1'b0;
    bit         rd_blocked = 1'b0;
    logic [8:0] rd_exp = '0;
    logic [8:0] last_q = '0;

    dc_fifo9_progflags #(.DEPTH(DEPTH)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
        .ld_wen2(ld_wen2), .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .oe_n(oe_n), .q(q), .empty_n(empty_n), .full_n(full_n),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    initial forever #2.0 wclk = ~wclk;
    initial forever #3.3 rclk = ~rclk;

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
        end
    endtask

    // One write-clock step; the model pushes only if the port would accept.
    task automatic wr(input bit en, input bit wen2, input logic [8:0] d);
        @(negedge wclk);
        check(!full_n || mq.size() < DEPTH, "R10 full_n high with no room", mq.size(), DEPTH - 1);
        check(!paf_n || (DEPTH - mq.size()) > foff_m, "R9 paf_n high at threshold", DEPTH - mq.size(), foff_m + 1);
        wen1_n  = !en;
        ld_wen2 = wen2;
        din     = d;
        if (en && wen2 && full_n) mq.push_back(d);
    endtask

    // One read-clock step; checks the result of the previous step first.
    task automatic rd(input bit en1, input bit en2);
        @(negedge rclk);
        if (rd_pend) check(q === rd_exp, "R1/R2 data order", int'(q), int'(rd_exp));
        else if (rd_blocked) check(q === last_q, "R3 q held on read while empty", int'(q), int'(last_q));
        else check(q === last_q, "R2 q held without full read enable", int'(q), int'(last_q));
        last_q = q;
        check(!empty_n || mq.size() > 0, "R10 empty_n high with no data", mq.size(), 1);
        check(!pae_n || mq.size() > eoff_m, "R8 pae_n high at threshold", mq.size(), eoff_m + 1);
        ren1_n = !en1;
        ren2_n = !en2;
        rd_blocked = en1 && en2 && !empty_n;
        if (en1 && en2 && empty_n) begin
            rd_exp  = mq.pop_front();
            rd_pend = 1'b1;
        end else begin
            rd_pend = 1'b0;
        end
    endtask

    // Let both pointers settle, then compare every flag exactly.
    task automatic settle(input string tag);
        repeat (12) @(negedge wclk);
        check(empty_n === (mq.size() != 0), {tag, " R10 empty_n"}, int'(empty_n), int'(mq.size() != 0));
        check(full_n === (mq.size() != DEPTH), {tag, " R10 full_n"}, int'(full_n), int'(mq.size() != DEPTH));
        check(pae_n === (mq.size() > eoff_m), {tag, " R8 pae_n"}, int'(pae_n), int'(mq.size() > eoff_m));
        check(paf_n === ((DEPTH - mq.size()) > foff_m), {tag, " R9 paf_n"}, int'(paf_n), int'((DEPTH - mq.size()) > foff_m));
    endtask

    task automatic do_reset(input bit ld_level);
        @(negedge wclk);
        rst_n = 1'b0; ld_wen2 = ld_level; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (8) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        ld_wen2 = 1'b1;
        mq.delete();
        eoff_m = 7; foff_m = 7;
        rd_pend = 1'b0; rd_blocked = 1'b0; last_q = '0;
        @(negedge wclk);
        check(empty_n === 1'b0, "R7 empty_n after reset", int'(empty_n), 0);
        check(pae_n === 1'b0, "R7 pae_n after reset", int'(pae_n), 0);
        check(full_n === 1'b1, "R7 full_n after reset", int'(full_n), 1);
        check(paf_n === 1'b1, "R7 paf_n after reset", int'(paf_n), 1);
        check(q === 9'd0, "R7 q after reset", int'(q), 0);
    endtask

    // Threshold load via the strobe; the caller releases the strobe.
    task automatic load(input logic [8:0] v);
        @(negedge wclk);
        wen1_n = 1'b0; ld_wen2 = 1'b0; din = v;
    endtask

    task automatic load_end();
        @(negedge wclk);
        wen1_n = 1'b1; ld_wen2 = 1'b1;
    endtask

    // Threshold readback of three values: empty, full, empty.
    task automatic readback(input int e, input int f);
        @(negedge rclk);
        ld_wen2 = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk);
        check(q === 9'(e), "R6 first readback is empty threshold", int'(q), e);
        @(negedge rclk);
        check(q === 9'(f), "R6 second readback is full threshold", int'(q), f);
        @(negedge rclk);
        check(q === 9'(e), "R6 third readback wraps to empty threshold", int'(q), e);
        ren1_n = 1'b1; ren2_n = 1'b1; ld_wen2 = 1'b1;
        last_q = q;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Dual-enable mode, reset state (R7)
        do_reset(1'b1);

        // R11 output enable
        @(negedge rclk);
        oe_n = 1'b1; #0.5;
        check(q === 9'bz, "R11 q high impedance", int'(q), 0);
        oe_n = 1'b0; #0.5;
        check(q === 9'd0, "R11 q driven", int'(q), 0);

        // R4 second enable low blocks writes
        for (int i = 0; i < 6; i++) wr(1'b1, 1'b0, 9'(100 + i));
        wr(1'b0, 1'b1, '0);
        settle("R4 wen2 low");

        // R8 boundary with default threshold 7
        for (int i = 0; i < 7; i++) wr(1'b1, 1'b1, 9'(i + 1));
        wr(1'b0, 1'b1, '0);
        settle("R8 seven words");
        wr(1'b1, 1'b1, 9'd8);
        wr(1'b0, 1'b1, '0);
        settle("R8 eight words");

        // R2 single read enable does nothing
        for (int i = 0; i < 3; i++) rd(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) rd(1'b0, 1'b1);
        rd(1'b0, 1'b0);
        settle("R2 half enable");

        // R9 boundary and R3 write while full
        for (int i = 0; i < DEPTH - 16; i++) wr(1'b1, 1'b1, 9'(i + 9));
        wr(1'b0, 1'b1, '0);
        settle("R9 free eight");
        wr(1'b1, 1'b1, 9'h1AA);
        wr(1'b0, 1'b1, '0);
        settle("R9 free seven");
        for (int i = 0; i < 10; i++) wr(1'b1, 1'b1, 9'(9'h1C0 + i));
        wr(1'b0, 1'b1, '0);
        settle("R3 full");
        check(mq.size() == DEPTH, "R3 model full", mq.size(), DEPTH);

        // Drain past empty (R2, R3)
        for (int i = 0; i < DEPTH + 4; i++) rd(1'b1, 1'b1);
        rd(1'b0, 1'b0);
        rd(1'b0, 1'b0);
        settle("R3 drained");

        // Concurrent traffic at unrelated clocks
        fork
            begin
                for (int i = 0; i < 3000; i++) wr(($urandom % 100) < 60, 1'b1, 9'($urandom));
                wr(1'b0, 1'b1, '0);
            end
            begin
                for (int i = 0; i < 2000; i++) rd(($urandom % 4) != 0, ($urandom % 4) != 0);
                rd(1'b0, 1'b0);
            end
        join
        rd(1'b0, 1'b0);
        settle("R1 after traffic");
        while (mq.size() > 0) rd(1'b1, 1'b1);
        rd(1'b0, 1'b0);
        settle("R1 traffic drained");

        // Programmable mode (R4, R5, R6, R7)
        do_reset(1'b0);
        readback(7, 7);
        load(9'd2);
        load_end();
        load(9'd3);
        load(9'd5);
        load_end();
        eoff_m = 3; foff_m = 5;
        settle("R5 loads store no word");
        for (int i = 0; i < 3; i++) wr(1'b1, 1'b1, 9'(200 + i));
        wr(1'b0, 1'b1, '0);
        settle("R5 empty threshold three");
        wr(1'b1, 1'b1, 9'd203);
        wr(1'b0, 1'b1, '0);
        settle("R5 four words");
        readback(3, 5);
        settle("R6 readback keeps data");
        for (int i = 0; i < DEPTH - 10; i++) wr(1'b1, 1'b1, 9'(i));
        wr(1'b0, 1'b1, '0);
        settle("R5 free six");
        wr(1'b1, 1'b1, 9'h155);
        wr(1'b0, 1'b1, '0);
        settle("R5 free five");
        while (mq.size() > 0) rd(1'b1, 1'b1);
        rd(1'b0, 1'b0);
        rd(1'b0, 1'b0);
        settle("R4 programmable drain");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule